// File: doc/BRIEF.md
# Two-Bit Handshake Capture Controller

This block accepts a two-bit parallel word from a host over a four-phase request/acknowledge handshake. It hands that word to a downstream serializer and flags it as ready. The host's request line is asynchronous, so it passes through a flop synchronizer before the control logic sees it. When the synchronized request is seen in the idle state, the block latches the data bits and raises two flags: an acknowledge toward the host and a full flag toward the serializer.

The captured word stays frozen until the serializer pulses its clear input. At that point both flags drop and the block returns to idle. The host should lower its request once it sees acknowledge. If the request is still high when the clear arrives, the block parks in a drain state until the request falls. This stops one request from being captured twice.

Two instances side by side give a four-bit input to a serializer.

Top module: `dual_bit_handshake_capture`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, after that edge `ack_o` and `full_o` are 0 and `word_o` is 2'b00. Reset is synchronous and active high.
- R2: Timing of a capture. In idle, if `req_i` goes high between edges and stays high, then after the third rising edge `ack_o` and `full_o` are 1. At that same edge `word_o[i]` takes the value of `data_i[i]`, with bit 0 mapping to bit 0. After the second edge `ack_o` is still 0.
- R3: `ack_o` and `full_o` always carry the same value.
- R4: While `ack_o` is high, `word_o` does not change, even if `data_i` or `req_i` change.
- R5: A high `clr_i` at a rising edge while `ack_o` is high drops `ack_o` and `full_o` to 0 after that edge. `word_o` keeps the captured value.
- R6: A `clr_i` pulse while `ack_o` is low has no effect on `ack_o`, `full_o` or `word_o`. Changes on `data_i` while idle also leave `word_o` unchanged.
- R7: If `req_i` is still high when a clear is taken, no new capture happens while the request stays high. A new capture needs the request to go low and then high again.
- R8: Reset wins over `clr_i` and `req_i`. Asserting reset while a word is held drops both flags and zeroes the word after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Asynchronous data-ready request from the host |
| data_i | input | 2 | Parallel data bits from the host |
| clr_i | input | 1 | Release pulse from the serializer |
| ack_o | output | 1 | Acknowledge toward the host |
| full_o | output | 1 | Word-available flag toward the serializer |
| word_o | output | 2 | Latched word |

## Verification
Two events can land in the same cycle: the serializer's clear and a host request that is still high.

The bench provokes this by holding the request high through a clear. It then checks that the flags stay low across several cycles and come back only after the request falls and rises again.

The bench also drops the request early, so the synchronized request falls close to the clear edge. It fires clear pulses while idle, and it asserts reset together with clear and request while a word is held. Each outcome is compared against an expected word built from the random data the bench drove.

// File: rtl/hs_cap_pkg.sv
package hs_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/hs_req_sync.sv
module hs_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
        if (rst_i) chain_d = '0;
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/hs_capture_fsm.sv
module hs_capture_fsm
    import hs_cap_pkg::*;
#(
    parameter int WORD_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_sync_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              clr_i,
    output logic              ack_o,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        cap_state_e        state;
        logic              ack;
        logic              full;
        logic [WORD_W-1:0] word;
    } cap_regs_t;

    cap_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_sync_i) begin
                    r_d.state = ST_HOLD;
                    r_d.word  = data_i;
                    r_d.ack   = 1'b1;
                    r_d.full  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (clr_i) begin
                    r_d.ack   = 1'b0;
                    r_d.full  = 1'b0;
                    r_d.state = req_sync_i ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (!req_sync_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (rst_i) begin
            r_d.state = ST_IDLE;
            r_d.ack   = 1'b0;
            r_d.full  = 1'b0;
            r_d.word  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign ack_o  = r_q.ack;
    assign full_o = r_q.full;
    assign word_o = r_q.word;

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (!r_q.ack && !r_q.full && r_q.word == '0)); // R1
    AST_RISE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(r_q.ack) |-> $past(req_sync_i)); // R2
    AST_FLAGS_AGREE: assert property (@(posedge clk_i) disable iff (rst_i)
        r_q.ack == r_q.full); // R3
    AST_WORD_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.ack && $past(r_q.ack)) |-> $stable(r_q.word)); // R4
    AST_CLR_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.ack && clr_i) |=> !r_q.ack); // R5
    AST_IDLE_CLR_INERT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!r_q.ack && !req_sync_i) |=> (!r_q.ack && $stable(r_q.word))); // R6
    AST_NO_RECAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        (r_q.state == ST_DRAIN) |=> !r_q.ack); // R7

endmodule

// File: rtl/dual_bit_handshake_capture.sv
module dual_bit_handshake_capture #(
    parameter int WORD_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              clr_i,
    output logic              ack_o,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);
    logic req_sync;

    hs_req_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (req_i),
        .sync_o  (req_sync)
    );

    hs_capture_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .req_sync_i (req_sync),
        .data_i     (data_i),
        .clr_i      (clr_i),
        .ack_o      (ack_o),
        .full_o     (full_o),
        .word_o     (word_o)
    );

    AST_RESET_WINS: assert property (@(posedge clk_i)
        (rst_i && clr_i) |=> (!ack_o && !full_o)); // R8

endmodule

// File: tb/dual_bit_handshake_capture_tb.sv
module dual_bit_handshake_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, req, clr;
    logic [1:0] data;
    logic       ack, full;
    logic [1:0] word;
    int         total = 0;
    int         bad   = 0;
    logic [1:0] exp_word;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bit_handshake_capture dut_i (
        .clk_i(clk), .rst_i(rst), .req_i(req), .data_i(data), .clr_i(clr),
        .ack_o(ack), .full_o(full), .word_o(word)
    );

    function automatic logic [1:0] flip_word(input logic [1:0] w);
        return ~w;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_state(input string tag, input logic ea, input logic [1:0] ew);
        chk(ack == ea, {tag, " ack"}, ack, ea);
        chk(full == ea, {tag, " full R3"}, full, ea);
        chk(word == ew, {tag, " word"}, word, ew);
    endtask

    task automatic transfer(input logic [1:0] d, input bit early_drop, input int gap);
        data = d;
        req  = 1'b1;
        tick(2);
        chk(ack == 1'b0, "R2 ack early", ack, 0);
        tick(1);
        exp_word = d;
        chk_state("R2 capture", 1'b1, exp_word);
        data = flip_word(d);
        if (early_drop) req = 1'b0;
        tick(gap);
        chk_state("R4 frozen", 1'b1, exp_word);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        chk_state("R5 release", 1'b0, exp_word);
        if (!early_drop) begin
            data = d;
            tick(4);
            chk_state("R7 no recapture", 1'b0, exp_word);
            req = 1'b0;
        end
        tick(4);
        chk_state("R7 idle after drop", 1'b0, exp_word);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req = 1'b0; clr = 1'b0; data = 2'b11;
        tick(3);
        chk_state("R1 reset", 1'b0, 2'b00);
        rst = 1'b0;
        tick(1);
        chk_state("R1 after release", 1'b0, 2'b00);

        transfer(2'b01, 1'b1, 0);
        transfer(2'b10, 1'b0, 2);

        clr = 1'b1; data = 2'b11;
        tick(1);
        clr = 1'b0;
        tick(2);
        chk_state("R6 idle clear", 1'b0, exp_word);

        for (int k = 0; k < 40; k++) begin
            logic [1:0] d;
            d = 2'($urandom_range(0, 3));
            transfer(d, 1'($urandom_range(0, 1)), int'($urandom_range(0, 5)));
        end

        data = 2'b11; req = 1'b1;
        tick(3);
        chk_state("R8 pre-reset hold", 1'b1, 2'b11);
        rst = 1'b1; clr = 1'b1;
        tick(1);
        chk_state("R8 reset wins", 1'b0, 2'b00);
        rst = 1'b0; clr = 1'b0; req = 1'b0;
        tick(4);
        chk_state("R8 idle after reset", 1'b0, 2'b00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule